// File: doc/BRIEF.md
# 16-bit ALU with status flags

This block is the data path of a small 16-bit register machine. It takes a source operand, a destination operand, a four-bit operation code, a byte/word select and an incoming carry. From these it forms a result and a write-back enable in the same cycle. It also computes new carry (C), zero (Z), negative (N) and overflow (V) flags, which are held in a flag register and updated on the clock edge when `exec` is high.

It covers the two-operand arithmetic and logic operations. These include a packed-decimal add, compare and bit-test operations that only set flags, and bit-clear and bit-set operations that leave the flags alone. It also covers the one-operand operations: an arithmetic right shift, a right rotate through carry, a byte swap and a sign extension.

Operand fetch, addressing and memory access belong to the surrounding core. That core supplies `carry_in`, which is normally the current C flag, and writes `result` back when `result_we` is high.

Top module: `flag_alu`

## Requirements
- R1: ADD (op 1) returns dst+src, and ADDC (op 2) returns dst+src+carry_in. C is the carry out of the operand's top bit, and V is set on signed overflow.
- R2: SUB (op 3) returns dst+NOT(src)+1, and SUBC (op 4) returns dst+NOT(src)+carry_in. C=1 means no borrow, and V is set on signed overflow.
- R3: CMP (op 5, dst−src, flags as SUB) and BIT (op 7, src AND dst) drive `result_we` low and only update flags. Every other op drives `result_we` high.
- R4: DADD (op 6) adds dst, src and carry_in as packed decimal, digit by digit. C is set when the decimal sum exceeds 99 in byte mode or 9999 in word mode, and V is cleared.
- R5: AND (op 11), XOR (op 10) and BIT produce the bitwise result. They set C to NOT Z and clear V.
- R6: MOV (op 0) passes src through, BIC (op 8) returns NOT(src) AND dst, and BIS (op 9) returns src OR dst. All three leave every flag unchanged.
- R7: RRA (op 12) shifts dst right and keeps its top bit in place. RRC (op 13) shifts dst right and moves carry_in into the top bit. Both move the old bit 0 into C and clear V.
- R8: SWPB (op 14) exchanges the two bytes of dst and leaves the flags unchanged. SXT (op 15) copies bit 7 of dst into bits 15..8, sets C to NOT Z and clears V. Both always work on the full 16-bit word.
- R9: When `byte_mode` is high, all other ops use only bits 7..0 of the operands. The result has bits 15..8 cleared, and C, N and V refer to bit 7.
- R10: For every op that updates flags, Z is set when the result at the selected width is zero, and N is a copy of the result's top bit at that width.
- R11: The flag outputs reset to 0. They change only at a clock edge where `exec` is high and the op updates flags; otherwise they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Commit this cycle's flag update at the next edge |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 = byte width, 0 = word width |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| carry_in | input | 1 | Incoming carry |
| result | output | 16 | Operation result (combinational) |
| result_we | output | 1 | Result should be written back |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
`result` and `result_we` are combinational and are valid in the same cycle as the inputs. The flags appear one clock edge later, at the edge closing the cycle in which `exec` was high. The bench drives each operation at a falling edge and queues its expected result, enable and flag values. The monitor pops and compares one item 1 ns after the following rising edge, when the inputs are still steady and the flag register has just taken the update. Operations issued with `exec` low are expected to show the previous flags unchanged.

// File: rtl/flag_alu.sv
module flag_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec,
  input  logic [3:0]  op,
  input  logic        byte_mode,
  input  logic [15:0] src,
  input  logic [15:0] dst,
  input  logic        carry_in,
  output logic [15:0] result,
  output logic        result_we,
  output logic        flag_c,
  output logic        flag_z,
  output logic        flag_n,
  output logic        flag_v
);

  localparam logic [3:0] OP_MOV  = 4'd0,  OP_ADD  = 4'd1,  OP_ADDC = 4'd2,  OP_SUB  = 4'd3;
  localparam logic [3:0] OP_SUBC = 4'd4,  OP_CMP  = 4'd5,  OP_DADD = 4'd6,  OP_BIT  = 4'd7;
  localparam logic [3:0] OP_BIC  = 4'd8,  OP_BIS  = 4'd9,  OP_XOR  = 4'd10, OP_AND  = 4'd11;
  localparam logic [3:0] OP_RRA  = 4'd12, OP_RRC  = 4'd13, OP_SWPB = 4'd14, OP_SXT  = 4'd15;

  logic        eb;
  logic [15:0] mask, a, sm, b;
  logic        is_sub, cin_eff;
  logic [16:0] sum_w;
  logic [15:0] sum_r;
  logic        sum_c, sum_v;
  logic [15:0] dres;
  logic        dcar;
  logic [15:0] res;
  logic        nc, nv, upd, rz, rn;

  assign eb   = byte_mode && !(op == OP_SWPB || op == OP_SXT);
  assign mask = eb ? 16'h00FF : 16'hFFFF;
  assign a    = dst & mask;
  assign sm   = src & mask;

  assign is_sub  = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign b       = is_sub ? (~src & mask) : sm;
  assign cin_eff = (op == OP_ADD) ? 1'b0 : (op == OP_SUB || op == OP_CMP) ? 1'b1 : carry_in;
  assign sum_w   = {1'b0, a} + {1'b0, b} + {16'b0, cin_eff};
  assign sum_r   = sum_w[15:0] & mask;
  assign sum_c   = eb ? sum_w[8] : sum_w[16];
  assign sum_v   = eb ? (a[7] == b[7]) && (sum_r[7] != a[7])
                      : (a[15] == b[15]) && (sum_r[15] != a[15]);

  always_comb begin
    logic [4:0] dsum;
    logic       dc;
    dc   = carry_in;
    dres = '0;
    dcar = 1'b0;
    for (int i = 0; i < 4; i++) begin
      dsum = {1'b0, a[4*i +: 4]} + {1'b0, sm[4*i +: 4]} + {4'b0, dc};
      if (dsum > 5'd9) begin
        dsum = dsum + 5'd6;
        dc   = 1'b1;
      end else begin
        dc   = 1'b0;
      end
      dres[4*i +: 4] = dsum[3:0];
      if (i == 1 && eb) dcar = dc;
      if (i == 3 && !eb) dcar = dc;
    end
  end

  always_comb begin
    res = sm;
    nc  = 1'b0;
    nv  = 1'b0;
    upd = 1'b1;
    case (op)
      OP_MOV:                                 upd = 1'b0;
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res = sum_r;
        nc  = sum_c;
        nv  = sum_v;
      end
      OP_DADD: begin
        res = dres & mask;
        nc  = dcar;
      end
      OP_BIT, OP_AND:                         res = a & sm;
      OP_XOR:                                 res = a ^ sm;
      OP_BIC: begin
        res = a & ~sm;
        upd = 1'b0;
      end
      OP_BIS: begin
        res = a | sm;
        upd = 1'b0;
      end
      OP_RRA: begin
        res = eb ? {8'h00, a[7], a[7:1]} : {a[15], a[15:1]};
        nc  = a[0];
      end
      OP_RRC: begin
        res = eb ? {8'h00, carry_in, a[7:1]} : {carry_in, a[15:1]};
        nc  = a[0];
      end
      OP_SWPB: begin
        res = {dst[7:0], dst[15:8]};
        upd = 1'b0;
      end
      OP_SXT:                                 res = {{8{dst[7]}}, dst[7:0]};
      default:                                upd = 1'b0;
    endcase
    rz = eb ? (res[7:0] == 8'h00) : (res == 16'h0000);
    rn = eb ? res[7] : res[15];
    if (op == OP_BIT || op == OP_AND || op == OP_XOR || op == OP_SXT) nc = !rz;
  end

  assign result    = res;
  assign result_we = !(op == OP_CMP || op == OP_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_v <= 1'b0;
    end else if (exec && upd) begin
      flag_c <= nc;
      flag_z <= rz;
      flag_n <= rn;
      flag_v <= nv;
    end
  end

endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        exec,
  input logic [3:0]  op,
  input logic        byte_mode,
  input logic [15:0] src,
  input logic [15:0] dst,
  input logic        carry_in,
  input logic [15:0] result,
  input logic        result_we,
  input logic        flag_c,
  input logic        flag_z,
  input logic        flag_n,
  input logic        flag_v
);

  assert_test_ops_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd5 || op == 4'd7) |-> !result_we);

  assert_flags_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable({flag_c, flag_z, flag_n, flag_v}));

  assert_quiet_ops_keep_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == 4'd0 || op == 4'd8 || op == 4'd9 || op == 4'd14))
      |=> $stable({flag_c, flag_z, flag_n, flag_v}));

  assert_mov_passes_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 && !byte_mode) |-> result == src);

  assert_byte_upper_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode && op != 4'd14 && op != 4'd15) |-> result[15:8] == 8'h00);

  assert_logic_carry_not_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == 4'd7 || op == 4'd10 || op == 4'd11)) |=> (!flag_v && flag_c == !flag_z));

  assert_decimal_clears_v_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 4'd6) |=> !flag_v);

endmodule

bind flag_alu flag_alu_checker u_flag_alu_checker (.*);

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        byte_mode = 1'b0;
  logic [15:0] src = 16'h0, dst = 16'h0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        result_we, flag_c, flag_z, flag_n, flag_v;

  always #4 clk = ~clk;

  flag_alu i_flag_alu (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .byte_mode(byte_mode),
    .src(src), .dst(dst), .carry_in(carry_in), .result(result), .result_we(result_we),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
  );

  typedef struct {
    logic [15:0] r;
    logic        we;
    logic [3:0]  f;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mc = 0, mz = 0, mn = 0, mv = 0;

  function automatic int sg(int x, int hb);
    return (x >= hb) ? x - 2 * hb : x;
  endfunction

  function automatic int from_bcd(int x);
    int v = 0;
    int p = 1;
    for (int i = 0; i < 4; i++) begin
      v += ((x >> (4 * i)) & 15) * p;
      p *= 10;
    end
    return v;
  endfunction

  function automatic int to_bcd(int x);
    int v = 0;
    int t = x;
    for (int i = 0; i < 4; i++) begin
      v |= (t % 10) << (4 * i);
      t /= 10;
    end
    return v;
  endfunction

  task automatic run(input int o, input bit bm, input int s, input int d, input bit ci,
                     input bit ex, input string tag);
    int mask, hb, a, sv, r, t, sd, cc, lim;
    bit wide, upd, nc, nv, z, n, we;
    item_t it;
    @(negedge clk);
    op = o[3:0]; byte_mode = bm; src = s[15:0]; dst = d[15:0]; carry_in = ci; exec = ex;
    wide = (o == 14 || o == 15);
    mask = (bm && !wide) ? 255 : 65535;
    hb   = (bm && !wide) ? 128 : 32768;
    a  = d & mask;
    sv = s & mask;
    upd = 1; nc = 0; nv = 0; r = 0;
    case (o)
      0: begin r = sv; upd = 0; end
      1, 2: begin
        cc = (o == 1) ? 0 : int'(ci);
        t = a + sv + cc; r = t & mask; nc = (t > mask);
        sd = sg(a, hb) + sg(sv, hb) + cc; nv = (sd >= hb) || (sd < -hb);
      end
      3, 4, 5: begin
        cc = (o == 4) ? int'(ci) : 1;
        t = a + ((~sv) & mask) + cc; r = t & mask; nc = (t > mask);
        sd = sg(a, hb) - sg(sv, hb) - (1 - cc); nv = (sd >= hb) || (sd < -hb);
      end
      6: begin
        lim = bm ? 100 : 10000;
        t = from_bcd(a) + from_bcd(sv) + int'(ci);
        nc = (t >= lim); r = to_bcd(t % lim);
      end
      7, 11: r = a & sv;
      10: r = a ^ sv;
      8: begin r = a & ~sv & mask; upd = 0; end
      9: begin r = a | sv; upd = 0; end
      12: begin r = (a >> 1) | (a & hb); nc = a[0]; end
      13: begin r = (a >> 1) | (ci ? hb : 0); nc = a[0]; end
      14: begin r = ((d & 255) << 8) | ((d >> 8) & 255); upd = 0; end
      15: r = (d & 128) ? ((d & 255) | 65280) : (d & 255);
      default: upd = 0;
    endcase
    z = (r == 0);
    n = ((r & hb) != 0);
    if (o == 7 || o == 10 || o == 11 || o == 15) nc = !z;
    we = !(o == 5 || o == 7);
    if (ex && upd) begin mc = nc; mz = z; mn = n; mv = nv; end
    it.r = r[15:0]; it.we = we; it.f = {mc, mz, mn, mv}; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (result !== e.r || result_we !== e.we ||
            {flag_c, flag_z, flag_n, flag_v} !== e.f) begin
          errors++;
          $display("FAIL %s: got result=%h we=%b CZNV=%b, expected result=%h we=%b CZNV=%b",
                   e.tag, result, result_we, {flag_c, flag_z, flag_n, flag_v}, e.r, e.we, e.f);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({flag_c, flag_z, flag_n, flag_v} !== 4'b0000) begin
      errors++;
      $display("FAIL R11 reset: got CZNV=%b, expected CZNV=0000", {flag_c, flag_z, flag_n, flag_v});
    end
    run(1,  0, 16'h0001, 16'h7FFF, 0, 1, "R1 add signed overflow");
    run(1,  0, 16'h0001, 16'hFFFF, 1, 1, "R1 R10 add carry to zero");
    run(2,  0, 16'h0010, 16'h0020, 1, 1, "R1 addc with carry");
    run(3,  0, 16'h0003, 16'h0005, 0, 1, "R2 sub no borrow");
    run(3,  0, 16'h0005, 16'h0003, 0, 1, "R2 R10 sub negative");
    run(4,  0, 16'h0003, 16'h0005, 0, 1, "R2 subc borrow in");
    run(3,  0, 16'h0001, 16'h8000, 1, 1, "R2 sub signed overflow");
    run(5,  0, 16'h1234, 16'h1234, 0, 1, "R3 cmp equal no write");
    run(7,  0, 16'h0008, 16'h000C, 0, 1, "R3 R5 bit test nonzero");
    run(7,  0, 16'h0001, 16'h000C, 0, 1, "R3 R5 bit test zero");
    run(6,  0, 16'h4321, 16'h1234, 1, 1, "R4 dadd word");
    run(6,  0, 16'h0001, 16'h9999, 0, 1, "R4 dadd word wrap");
    run(6,  1, 16'hAB01, 16'hCD99, 0, 1, "R4 R9 dadd byte wrap");
    run(11, 0, 16'h00F0, 16'h0F0F, 1, 1, "R5 and zero");
    run(10, 0, 16'h0006, 16'h0003, 0, 1, "R5 xor");
    run(1,  0, 16'h8000, 16'h8000, 0, 1, "R1 set flags before quiet ops");
    run(0,  0, 16'hBEEF, 16'h0000, 0, 1, "R6 mov keeps flags");
    run(8,  0, 16'h0003, 16'h0006, 0, 1, "R6 bic");
    run(9,  0, 16'h0008, 16'h0004, 0, 1, "R6 bis");
    run(12, 0, 16'h0000, 16'hF009, 0, 1, "R7 rra word");
    run(13, 0, 16'h0000, 16'hF804, 0, 1, "R7 rrc word carry clear");
    run(13, 0, 16'h0000, 16'h0003, 1, 1, "R7 rrc word carry set");
    run(12, 1, 16'h0000, 16'h0181, 0, 1, "R7 R9 rra byte");
    run(14, 1, 16'h0000, 16'hFC02, 0, 1, "R8 swpb word always");
    run(15, 1, 16'h0000, 16'h12FC, 0, 1, "R8 sxt negative");
    run(15, 0, 16'h0000, 16'hFF00, 0, 1, "R8 sxt zero");
    run(1,  1, 16'h3301, 16'h44FF, 0, 1, "R9 byte add carry");
    run(3,  1, 16'h0001, 16'h0080, 0, 1, "R9 byte sub overflow");
    run(0,  1, 16'hABCD, 16'h0000, 0, 1, "R9 byte mov");
    run(1,  0, 16'h0001, 16'hFFFF, 0, 0, "R11 exec low holds flags");
    run(11, 0, 16'h0000, 16'h0000, 0, 0, "R11 exec low logic holds");
    exec = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule